// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

This block produces a periodic wakeup event for a small controller. It counts ticks from one of two slow time bases, a nominal 1 kHz source and a nominal 32 kHz source, and sets a status flag each time a programmed number of ticks has gone by. Both time bases are single-cycle tick-enable pulses in the one synchronous clock domain of the block. A local enable decides whether the flag drives the interrupt line.

Software uses one 8-bit control/status register through a plain write strobe and a combinational read port. The register holds the source select, the interrupt enable and a 3-bit period code. It also holds a status flag that software can only read, and an acknowledge bit that software can only write. Code zero turns the timer off. The slow source always runs in low-power stop mode. The fast source counts during stop only when two low-voltage enables from the power controller are both high.

Top module: `wkup_timer`

## Requirements
- R1: After reset the register reads 0x00 and `irq_o` is 0. The register layout is: bit 7 is the status flag (read-only), bit 6 is the acknowledge bit (write-only, always reads 0), bit 5 is the source select (0 = slow tick, 1 = fast tick), bit 4 is the interrupt enable, bit 3 reads 0, and bits 2:0 hold the period code.
- R2: Period code 1 gives 8 ticks. Codes 2 to 7 give 2^(code+3) ticks, that is 32, 64, 128, 256, 512 and 1024. The flag sets on the edge that counts the last tick of the period since the most recent restart.
- R3: With period code 0 the counter does not run and the flag never sets.
- R4: Only ticks of the selected source advance the counter. Ticks on the other source have no effect.
- R5: Writing 1 to bit 6 clears the flag. Writing 0 to bit 6 leaves the flag as it is.
- R6: `irq_o` is a register equal to flag AND enable, updated on the same edge as the flag. Clearing the enable masks `irq_o` but does not stop the flag from setting.
- R7: In stop mode (`stop_mode_i` high) the slow source still counts. The fast source counts only while `lvd_en_i` and `lvd_stop_en_i` are both high.
- R8: A write that changes the period code or the source select, or that writes 1 to the acknowledge bit, restarts the counter from zero. A write that changes neither and does not acknowledge leaves the count alone.
- R9: If an acknowledge write and a period expiry fall in the same cycle, the flag stays set.
- R10: A write with bit 7 set cannot set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_slow_i | input | 1 | Tick enable of the nominal 1 kHz source |
| tick_fast_i | input | 1 | Tick enable of the nominal 32 kHz source |
| stop_mode_i | input | 1 | High while the system is in stop mode |
| lvd_en_i | input | 1 | Low-voltage detect enable |
| lvd_stop_en_i | input | 1 | Low-voltage detect enable in stop mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an acknowledge write that lands on the very edge where the next period expires. The flag has to be set already. The count has to stand one tick short of terminal. The write strobe and the final tick have to arrive on the same clock edge. The bench gets there in steps. It lets the flag set and leaves it unacknowledged, so the counter wraps to zero. It then feeds exactly one tick fewer than the period, and drives the acknowledge write and the last tick together in one cycle. A second demanding case is a mid-period code change. Without a restart, the leftover count would make the flag set early, so the bench counts the full new period after the change.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   // register field positions (software-visible layout)
   localparam int FLAG_BIT = 7;
   localparam int ACK_BIT  = 6;
   localparam int SEL_BIT  = 5;
   localparam int IEN_BIT  = 4;
   localparam int PER_LSB  = 0;

   typedef enum logic {SRC_SLOW = 1'b0, SRC_FAST = 1'b1} src_sel_e;

   // log2 of terminal count for a period code; code 1 uses the base,
   // higher codes step from base+2 upward
   function automatic int term_log2(input int code, input int base_log2);
      if (code <= 1) return base_log2;
      return code + base_log2;
   endfunction
endpackage

// File: rtl/wkup_src_gate.sv
module wkup_src_gate
   import wkup_pkg::*;
(
   input  logic     tick_slow_i,
   input  logic     tick_fast_i,
   input  logic     stop_mode_i,
   input  logic     lvd_en_i,
   input  logic     lvd_stop_en_i,
   input  src_sel_e src_sel_i,
   output logic     tick_o
);
   logic fast_alive;

   // fast source survives stop only with both low-voltage enables
   assign fast_alive = !stop_mode_i || (lvd_en_i && lvd_stop_en_i);

   always_comb begin
      unique case (src_sel_i)
         SRC_FAST: tick_o = tick_fast_i && fast_alive;
         default:  tick_o = tick_slow_i;
      endcase
   end
endmodule

// File: rtl/wkup_counter.sv
module wkup_counter
   import wkup_pkg::*;
#(
   parameter int PER_W     = 3,
   parameter int BASE_LOG2 = 3,
   parameter int CNT_W     = BASE_LOG2 + (1 << PER_W) - 1
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [PER_W-1:0] period_i,
   output logic             expire_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int NUM_CODES = 1 << PER_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;
   logic [CNT_W-1:0] last_tab [NUM_CODES];
   logic             running;

   // per-code terminal value, built at elaboration
   for (genvar c = 0; c < NUM_CODES; c++) begin : g_term
      localparam int SH = term_log2(c, BASE_LOG2);
      if (SH > CNT_W) begin : g_bad
         $error("wkup_counter: CNT_W too small for period code");
      end
      assign last_tab[c] = CNT_W'((64'd1 << SH) - 64'd1);
   end

   assign running  = (period_i != '0);
   assign last_cnt = last_tab[period_i];
   assign expire_o = running && tick_i && (cnt_q == last_cnt);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i || !running) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
   import wkup_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PER_W  = 3
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              expire_i,
   output logic [DATA_W-1:0] rdata_o,
   output src_sel_e          src_sel_o,
   output logic [PER_W-1:0]  period_o,
   output logic              restart_o,
   output logic              irq_o
);
   logic             flag_q, flag_d;
   logic             ien_q, ien_d;
   src_sel_e         sel_q, sel_d;
   logic [PER_W-1:0] per_q, per_d;
   logic             ack_wr;
   logic             irq_q;
   logic             unused_wbits;

   assign ack_wr = wr_i && wdata_i[ACK_BIT];
   assign sel_d  = wr_i ? src_sel_e'(wdata_i[SEL_BIT]) : sel_q;
   assign ien_d  = wr_i ? wdata_i[IEN_BIT] : ien_q;
   assign per_d  = wr_i ? wdata_i[PER_LSB +: PER_W] : per_q;

   // expiry wins over a simultaneous acknowledge
   always_comb begin
      flag_d = flag_q;
      if (expire_i)    flag_d = 1'b1;
      else if (ack_wr) flag_d = 1'b0;
   end

   assign restart_o = ack_wr || (wr_i && ((per_d != per_q) || (sel_d != sel_q)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
         ien_q  <= 1'b0;
         sel_q  <= SRC_SLOW;
         per_q  <= '0;
         irq_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         ien_q  <= ien_d;
         sel_q  <= sel_d;
         per_q  <= per_d;
         irq_q  <= flag_d && ien_d;
      end
   end

   always_comb begin
      rdata_o                      = '0;
      rdata_o[FLAG_BIT]            = flag_q;
      rdata_o[SEL_BIT]             = sel_q;
      rdata_o[IEN_BIT]             = ien_q;
      rdata_o[PER_LSB +: PER_W]    = per_q;
   end

   assign unused_wbits = ^{wdata_i[FLAG_BIT], wdata_i[3]};
   assign src_sel_o    = sel_q;
   assign period_o     = per_q;
   assign irq_o        = irq_q;
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
   import wkup_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PER_W     = 3,
   parameter int BASE_LOG2 = 3
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_slow_i,
   input  logic              tick_fast_i,
   input  logic              stop_mode_i,
   input  logic              lvd_en_i,
   input  logic              lvd_stop_en_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);
   localparam int CNT_W = BASE_LOG2 + (1 << PER_W) - 1;

   if (DATA_W != 8) begin : g_bad_dw
      $error("wkup_timer: register layout needs DATA_W == 8");
   end
   if (PER_W + 1 > IEN_BIT) begin : g_bad_pw
      $error("wkup_timer: PER_W overlaps control bits");
   end
   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("wkup_timer: BASE_LOG2 must be positive");
   end

   src_sel_e         src_sel_w;
   logic [PER_W-1:0] period_w;
   logic             restart_w;
   logic             tick_w;
   logic             expire_w;
   logic [CNT_W-1:0] cnt_w;

   wkup_src_gate u_gate (
      .tick_slow_i   (tick_slow_i),
      .tick_fast_i   (tick_fast_i),
      .stop_mode_i   (stop_mode_i),
      .lvd_en_i      (lvd_en_i),
      .lvd_stop_en_i (lvd_stop_en_i),
      .src_sel_i     (src_sel_w),
      .tick_o        (tick_w)
   );

   wkup_counter #(
      .PER_W     (PER_W),
      .BASE_LOG2 (BASE_LOG2),
      .CNT_W     (CNT_W)
   ) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_w),
      .restart_i (restart_w),
      .period_i  (period_w),
      .expire_o  (expire_w),
      .cnt_o     (cnt_w)
   );

   wkup_regs #(
      .DATA_W (DATA_W),
      .PER_W  (PER_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_wr_i),
      .wdata_i   (reg_wdata_i),
      .expire_i  (expire_w),
      .rdata_o   (reg_rdata_o),
      .src_sel_o (src_sel_w),
      .period_o  (period_w),
      .restart_o (restart_w),
      .irq_o     (irq_o)
   );
endmodule

// File: rtl/wkup_timer_chk.sv
module wkup_timer_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 10
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              irq,
   input logic              stop,
   input logic              lvde,
   input logic              lvdse,
   input logic              expire,
   input logic [CNT_W-1:0]  cnt
);
   // R1
   fixed_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[6] == 1'b0) && (rdata[3] == 1'b0));

   // R6
   irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (rdata[7] && rdata[4]));

   // R3
   off_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[2:0] == 3'd0 && !wr) |=> !$rose(rdata[7]));

   // R5
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[6] && !expire) |=> !rdata[7]);

   // R9
   expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> rdata[7]);

   // R10
   no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdata[7] && !expire) |=> !rdata[7]);

   // R7
   fast_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && rdata[5] && !(lvde && lvdse) && !wr) |=> $stable(cnt));
endmodule

bind wkup_timer wkup_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk    (clk_i),
   .rst_n  (rst_ni),
   .wr     (reg_wr_i),
   .wdata  (reg_wdata_i),
   .rdata  (reg_rdata_o),
   .irq    (irq_o),
   .stop   (stop_mode_i),
   .lvde   (lvd_en_i),
   .lvdse  (lvd_stop_en_i),
   .expire (expire_w),
   .cnt    (cnt_w)
);

// File: tb/wkup_timer_tb.sv
module wkup_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_slow = 1'b0, tick_fast = 1'b0;
   logic       stop = 1'b0, lvde = 1'b0, lvdse = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   wkup_timer u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .tick_slow_i(tick_slow), .tick_fast_i(tick_fast),
      .stop_mode_i(stop), .lvd_en_i(lvde), .lvd_stop_en_i(lvdse),
      .reg_wr_i(wr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // write {flag7, ack, sel, ien, 0, per}
   task automatic wreg(input bit f7, input bit ack, input bit sel, input bit ien, input logic [2:0] per);
      @(negedge clk);
      wr = 1'b1; wdata = {f7, ack, sel, ien, 1'b0, per};
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic ticks(input bit fast, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
      end
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 reset rdata", rdata, 8'h00);
      check("R1 reset irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_period_one();
      wreg(0, 1, 0, 0, 3'd1);
      ticks(0, 7);
      check("R2 code1 before end", {7'd0, rdata[7]}, 8'h00);
      ticks(0, 1);
      check("R2 code1 at 8", rdata, 8'h81);
      check("R6 masked irq", {7'd0, irq}, 8'h00);
      wreg(0, 0, 0, 1, 3'd1);
      check("R6 irq after enable", {7'd0, irq}, 8'h01);
      wreg(0, 0, 0, 1, 3'd1);
      check("R5 ack0 keeps flag", rdata, 8'h91);
      wreg(0, 1, 0, 1, 3'd1);
      check("R5 ack clears, reads 0", rdata, 8'h11);
      check("R6 irq drops", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_long_periods();
      wreg(0, 1, 0, 0, 3'd3);
      ticks(0, 63);
      check("R2 code3 at 63", {7'd0, rdata[7]}, 8'h00);
      ticks(0, 1);
      check("R2 code3 at 64", {7'd0, rdata[7]}, 8'h01);
      wreg(0, 1, 0, 0, 3'd7);
      ticks(0, 1023);
      check("R2 code7 at 1023", {7'd0, rdata[7]}, 8'h00);
      ticks(0, 1);
      check("R2 code7 at 1024", {7'd0, rdata[7]}, 8'h01);
   endtask

   task automatic t_off();
      wreg(0, 1, 0, 1, 3'd0);
      ticks(0, 1100);
      check("R3 code0 no flag", rdata, 8'h10);
      check("R3 code0 no irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_source();
      wreg(0, 1, 1, 0, 3'd1);
      ticks(0, 20);
      check("R4 slow ignored when fast selected", {7'd0, rdata[7]}, 8'h00);
      ticks(1, 8);
      check("R4 fast counts", {7'd0, rdata[7]}, 8'h01);
      wreg(0, 1, 0, 0, 3'd1);
      ticks(1, 20);
      check("R4 fast ignored when slow selected", {7'd0, rdata[7]}, 8'h00);
   endtask

   task automatic t_stop();
      wreg(0, 1, 1, 0, 3'd1);
      stop = 1'b1; lvde = 1'b1; lvdse = 1'b0;
      ticks(1, 12);
      check("R7 fast frozen, one enable", {7'd0, rdata[7]}, 8'h00);
      lvdse = 1'b1;
      ticks(1, 8);
      check("R7 fast runs with both enables", {7'd0, rdata[7]}, 8'h01);
      lvde = 1'b0; lvdse = 1'b0;
      wreg(0, 1, 0, 0, 3'd1);
      ticks(0, 8);
      check("R7 slow runs in stop", {7'd0, rdata[7]}, 8'h01);
      stop = 1'b0;
   endtask

   task automatic t_restart();
      wreg(0, 1, 0, 0, 3'd1);
      ticks(0, 5);
      wreg(0, 0, 0, 0, 3'd2);
      ticks(0, 31);
      check("R8 code change restarts", {7'd0, rdata[7]}, 8'h00);
      ticks(0, 1);
      check("R8 full new period", {7'd0, rdata[7]}, 8'h01);
      wreg(0, 1, 0, 0, 3'd1);
      ticks(0, 5);
      wreg(0, 0, 0, 1, 3'd1);
      ticks(0, 3);
      check("R8 same-value write keeps count", {7'd0, rdata[7]}, 8'h01);
      wreg(0, 1, 0, 0, 3'd1);
      ticks(0, 5);
      wreg(0, 1, 0, 0, 3'd1);
      ticks(0, 3);
      check("R8 ack restarts", {7'd0, rdata[7]}, 8'h00);
   endtask

   task automatic t_collide();
      wreg(0, 1, 0, 0, 3'd1);
      ticks(0, 8);
      ticks(0, 7);
      @(negedge clk);
      wr = 1'b1; wdata = 8'h41; tick_slow = 1'b1;
      @(negedge clk);
      wr = 1'b0; tick_slow = 1'b0;
      check("R9 expiry beats ack", {7'd0, rdata[7]}, 8'h01);
   endtask

   task automatic t_no_sw_set();
      wreg(0, 1, 0, 0, 3'd1);
      wreg(1, 0, 0, 1, 3'd1);
      check("R10 bit7 write ignored", rdata, 8'h11);
      check("R10 irq stays low", {7'd0, irq}, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period_one();
      t_long_periods();
      t_off();
      t_source();
      t_stop();
      t_restart();
      t_collide();
      t_no_sw_set();
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule